// File: doc/BRIEF.md
# Byte-Coded Three-State Pin Controller

This block is a small register file that sits on a host byte bus and drives the control pins of two attached devices, a line interface and a framer. The bottom of its map holds fixed identification and revision bytes. Above them, each of sixteen read-write registers owns one output pin. The byte stored in a register decides whether the pin is driven high, driven low or released to high impedance. One more register picks which clock feeds both devices: the host-supplied clock or an external one.

Software writes a full byte code per pin rather than a single bit. The value 01h drives the pin high, 00h drives it low, and any other byte releases it. Every register reads back the exact byte last written, so software can see each pin's state. The reset values leave the attached devices in T3 mode, sending all ones, and clocked from the host clock.

Top module: `tsp_ctrl_top`

## Requirements
- R1: After reset, the pin registers at 11h..20h hold 00,00,01,00,01,00,01,01,00,00,01,01,00,00,00,00 (hex, in address order), the clock-select register at 21h holds 01h, and `bus_rdata` is 00h.
- R2: Reads return fixed bytes: 0Dh at 00h, 00h at 02h, 00h at 03h and 01h at 04h. Addresses 05h, 06h and 07h return the fabrication, assembly and logic revision parameters, which default to 02h, 01h and 03h.
- R3: Reads of addresses that hold no register return 00h. These are 01h, 08h..10h and 22h..FFh.
- R4: Writes to the identification addresses or to unmapped addresses have no effect. No register value and no pin output changes.
- R5: A pin register holding 01h drives its pin high (`pin_drive`=1, `pin_level`=1). One holding 00h drives it low (`pin_drive`=1, `pin_level`=0). Any other byte releases it (`pin_drive`=0, `pin_level`=0).
- R6: Each pin register and the clock-select register read back exactly the last byte written, including codes that release the pin.
- R7: Address 11h+i controls bit i of `pin_drive`/`pin_level`. A write to one pin register changes no other pin.
- R8: A write is accepted on the rising clock edge where `bus_we` is high. The pin outputs reflect the new byte right after that edge.
- R9: Read data is registered. `bus_rdata` shows the addressed value after the edge where `bus_re` is high, and holds its value while `bus_re` is low.
- R10: `dev_clk` follows `ext_clk` when the clock-select register holds 00h. It follows `host_clk` for any other value, including the reset value 01h.
- R11: When `bus_we` and `bus_re` target the same register in one cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable, single cycle |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 8 | Registered read data |
| pin_level | output | 16 | Level driven on each controlled pin |
| pin_drive | output | 16 | Output enable per pin; 0 means high impedance |
| host_clk | input | 1 | Host-supplied clock source |
| ext_clk | input | 1 | External clock source |
| dev_clk | output | 1 | Selected clock fed to both devices |

## Verification
Every one of the 256 byte codes is written to every pin register. The pin pair is compared after each write, which tells the two driven codes apart from the 254 release codes and exposes any crosstalk between pins. The whole address space is read at reset and again after a sweep of writes to every non-writable address. These two reads separate the identification bytes, the unmapped zeros and the ignored writes. The clock select is driven with 00h, 01h and several other codes while the two clock inputs hold opposite levels, so a wrong route shows up directly on `dev_clk`.

// File: rtl/tsp_ctrl_pkg.sv
package tsp_ctrl_pkg;
   localparam int unsigned ADDR_W_DEF   = 8;
   localparam int unsigned DATA_W_DEF   = 8;
   localparam int unsigned NUM_PINS_DEF = 16;
   localparam int unsigned PIN_BASE_DEF = 'h11;

   // fixed identification bytes
   localparam logic [7:0] ID_BOARD = 8'h0D;
   localparam logic [7:0] ID_EXT_H = 8'h00;
   localparam logic [7:0] ID_EXT_M = 8'h00;
   localparam logic [7:0] ID_EXT_L = 8'h01;

   // decoded pin state
   typedef struct packed {
      logic level;
      logic drive;
   } pin_state_t;
endpackage

// File: rtl/tsp_id_rom.sv
module tsp_id_rom #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter logic [7:0]  FAB_REV   = 8'h02,
   parameter logic [7:0]  ASM_REV   = 8'h01,
   parameter logic [7:0]  LOGIC_REV = 8'h03
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [DATA_W-1:0] value
);
   import tsp_ctrl_pkg::*;

   always_comb begin
      hit   = 1'b1;
      value = '0;
      case (addr)
         ADDR_W'(0): value = DATA_W'(ID_BOARD);
         ADDR_W'(2): value = DATA_W'(ID_EXT_H);
         ADDR_W'(3): value = DATA_W'(ID_EXT_M);
         ADDR_W'(4): value = DATA_W'(ID_EXT_L);
         ADDR_W'(5): value = DATA_W'(FAB_REV);
         ADDR_W'(6): value = DATA_W'(ASM_REV);
         ADDR_W'(7): value = DATA_W'(LOGIC_REV);
         default:    hit   = 1'b0;
      endcase
   end
endmodule

// File: rtl/tsp_pin_slot.sv
module tsp_pin_slot #(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned MY_ADDR = 'h11,
   parameter logic        RST_ONE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              we,
   output logic [DATA_W-1:0] value,
   output tsp_ctrl_pkg::pin_state_t pin
);
   localparam logic [DATA_W-1:0] CODE_HI  = DATA_W'(1);
   localparam logic [DATA_W-1:0] CODE_LO  = '0;
   localparam logic [DATA_W-1:0] RST_CODE = RST_ONE ? CODE_HI : CODE_LO;

   logic hit;
   assign hit = we && (addr == ADDR_W'(MY_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   value <= RST_CODE;
      else if (hit) value <= wdata;
   end

   always_comb begin
      pin.drive = (value == CODE_HI) || (value == CODE_LO);
      pin.level = (value == CODE_HI);
   end
endmodule

// File: rtl/tsp_clk_route.sv
module tsp_clk_route #(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] sel_code,
   input  logic              host_clk,
   input  logic              ext_clk,
   output logic              dev_clk
);
   logic use_ext;
   assign use_ext = (sel_code == '0);
   assign dev_clk = use_ext ? ext_clk : host_clk;
endmodule

// File: rtl/tsp_ctrl_top.sv
module tsp_ctrl_top #(
   parameter int unsigned          ADDR_W    = tsp_ctrl_pkg::ADDR_W_DEF,
   parameter int unsigned          DATA_W    = tsp_ctrl_pkg::DATA_W_DEF,
   parameter int unsigned          NUM_PINS  = tsp_ctrl_pkg::NUM_PINS_DEF,
   parameter int unsigned          PIN_BASE  = tsp_ctrl_pkg::PIN_BASE_DEF,
   parameter logic [NUM_PINS-1:0]  PIN_RST   = 16'h0CD4,
   parameter logic [7:0]           FAB_REV   = 8'h02,
   parameter logic [7:0]           ASM_REV   = 8'h01,
   parameter logic [7:0]           LOGIC_REV = 8'h03
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic                bus_we,
   input  logic                bus_re,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic [NUM_PINS-1:0] pin_level,
   output logic [NUM_PINS-1:0] pin_drive,
   input  logic                host_clk,
   input  logic                ext_clk,
   output logic                dev_clk
);
   import tsp_ctrl_pkg::*;

   localparam int unsigned CLK_ADDR = PIN_BASE + NUM_PINS;

   initial begin
      if (DATA_W < 8) $fatal(1, "data width must hold a full byte code");
      if (PIN_BASE < 8) $fatal(1, "pin block overlaps identification bytes");
      if (CLK_ADDR >= (1 << ADDR_W)) $fatal(1, "map exceeds address space");
   end

   logic [DATA_W-1:0] slot_val [NUM_PINS];
   pin_state_t        slot_pin [NUM_PINS];
   logic [DATA_W-1:0] clk_sel;
   pin_state_t        clk_pin_unused;
   logic              id_hit;
   logic [DATA_W-1:0] id_val;
   logic [DATA_W-1:0] rd_next;

   tsp_id_rom #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .FAB_REV(FAB_REV), .ASM_REV(ASM_REV), .LOGIC_REV(LOGIC_REV)
   ) u_id (
      .addr(bus_addr), .hit(id_hit), .value(id_val)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      tsp_pin_slot #(
         .ADDR_W(ADDR_W), .DATA_W(DATA_W),
         .MY_ADDR(PIN_BASE + i), .RST_ONE(PIN_RST[i])
      ) u_slot (
         .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
         .we(bus_we), .value(slot_val[i]), .pin(slot_pin[i])
      );
      assign pin_level[i] = slot_pin[i].level;
      assign pin_drive[i] = slot_pin[i].drive;
   end

   tsp_pin_slot #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .MY_ADDR(CLK_ADDR), .RST_ONE(1'b1)
   ) u_clk_sel (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
      .we(bus_we), .value(clk_sel), .pin(clk_pin_unused)
   );

   tsp_clk_route #(.DATA_W(DATA_W)) u_route (
      .sel_code(clk_sel), .host_clk(host_clk), .ext_clk(ext_clk), .dev_clk(dev_clk)
   );

   always_comb begin
      rd_next = '0;
      if (id_hit) rd_next = id_val;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (bus_addr == ADDR_W'(PIN_BASE + i)) rd_next = slot_val[i];
      end
      if (bus_addr == ADDR_W'(CLK_ADDR)) rd_next = clk_sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_re) bus_rdata <= rd_next;
   end
endmodule

// File: rtl/tsp_ctrl_chk.sv
module tsp_ctrl_chk #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NUM_PINS = 16,
   parameter int unsigned PIN_BASE = 'h11
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic                bus_we,
   input logic                bus_re,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [NUM_PINS-1:0] pin_level,
   input logic [NUM_PINS-1:0] pin_drive,
   input logic                host_clk,
   input logic                ext_clk,
   input logic                dev_clk
);
   localparam int unsigned CLK_ADDR = PIN_BASE + NUM_PINS;

   logic unmapped;
   assign unmapped = (bus_addr == ADDR_W'(1)) ||
                     ((bus_addr > ADDR_W'(7)) && (bus_addr < ADDR_W'(PIN_BASE))) ||
                     (bus_addr > ADDR_W'(CLK_ADDR));

   p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> $stable(bus_rdata));

   p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && unmapped) |=> (bus_rdata == '0));

   p_ignored_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && ((bus_addr < ADDR_W'(PIN_BASE)) || (bus_addr > ADDR_W'(CLK_ADDR))))
      |=> ($stable(pin_drive) && $stable(pin_level)));

   p_clk_ext_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(CLK_ADDR) && bus_wdata == '0)
      |=> (dev_clk == ext_clk));

   p_clk_host_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(CLK_ADDR) && bus_wdata != '0)
      |=> (dev_clk == host_clk));

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
      p_pin_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == ADDR_W'(PIN_BASE + i) && bus_wdata == DATA_W'(1))
         |=> (pin_drive[i] && pin_level[i]));
      p_pin_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == ADDR_W'(PIN_BASE + i) && bus_wdata == '0)
         |=> (pin_drive[i] && !pin_level[i]));
      p_pin_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == ADDR_W'(PIN_BASE + i) && bus_wdata > DATA_W'(1))
         |=> !pin_drive[i]);
   end
endmodule

bind tsp_ctrl_top tsp_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PINS(NUM_PINS), .PIN_BASE(PIN_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
   .pin_level(pin_level), .pin_drive(pin_drive),
   .host_clk(host_clk), .ext_clk(ext_clk), .dev_clk(dev_clk)
);

// File: tb/tsp_ctrl_top_test.sv
`timescale 1ns/1ps
module tsp_ctrl_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [7:0]  bus_rdata;
   logic [15:0] pin_level;
   logic [15:0] pin_drive;
   logic        host_clk = 1'b0;
   logic        ext_clk = 1'b0;
   logic        dev_clk;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;
   logic [7:0] mdl [256];

   always #10 clk = ~clk;

   tsp_ctrl_top uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .pin_level(pin_level), .pin_drive(pin_drive),
      .host_clk(host_clk), .ext_clk(ext_clk), .dev_clk(dev_clk)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_drive();
      logic [15:0] v;
      for (int i = 0; i < 16; i++) v[i] = (mdl['h11 + i] <= 8'h01);
      return v;
   endfunction

   function automatic logic [15:0] exp_level();
      logic [15:0] v;
      for (int i = 0; i < 16; i++) v[i] = (mdl['h11 + i] == 8'h01);
      return v;
   endfunction

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      if (a >= 8'h11 && a <= 8'h21) mdl[a] = d;
   endtask

   task automatic rd(input logic [7:0] a);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   task automatic read_all(input string req);
      for (int a = 0; a < 256; a++) begin
         rd(8'(a));
         check(req, {24'h0, bus_rdata}, {24'h0, mdl[a]});
      end
   endtask

   initial begin
      #(20ns * 200000);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      // reference map from the requirements
      for (int a = 0; a < 256; a++) mdl[a] = 8'h00;
      mdl[0] = 8'h0D; mdl[4] = 8'h01;
      mdl[5] = 8'h02; mdl[6] = 8'h01; mdl[7] = 8'h03;
      for (int i = 0; i < 16; i++) mdl['h11 + i] = {7'h0, 1'((16'h0CD4 >> i) & 1)};
      mdl['h21] = 8'h01;

      repeat (3) @(negedge clk);
      check("R1 rdata at reset", {24'h0, bus_rdata}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 drive at reset", {16'h0, pin_drive}, {16'h0, 16'hFFFF});
      check("R1 level at reset", {16'h0, pin_level}, {16'h0, 16'h0CD4});
      host_clk = 1'b1; ext_clk = 1'b0; #1;
      check("R10 reset selects host clock", {31'h0, dev_clk}, 32'h1);

      // R1 R2 R3: full map at reset
      read_all("R2 R3 R1 reset map");

      // R9: rdata holds while re is low
      rd(8'h00);
      bus_addr = 8'h04;
      repeat (2) @(negedge clk);
      check("R9 rdata holds without re", {24'h0, bus_rdata}, 32'h0D);

      // R5 R6 R7 R8: every code on every pin
      for (int p = 0; p < 16; p++) begin
         for (int c = 0; c < 256; c++) begin
            wr(8'('h11 + p), 8'(c));
            check("R5 R7 R8 drive", {16'h0, pin_drive}, {16'h0, exp_drive()});
            check("R5 R7 R8 level", {16'h0, pin_level}, {16'h0, exp_level()});
            if ((c % 37) == 0 || c > 250) begin
               rd(8'('h11 + p));
               check("R6 readback", {24'h0, bus_rdata}, {24'h0, 8'(c)});
            end
         end
         wr(8'('h11 + p), 8'(p[0]));
      end

      // R4: writes to identification and unmapped addresses
      for (int a = 0; a < 256; a++) begin
         if (a < 'h11 || a > 'h21) begin
            wr(8'(a), 8'h01 ^ 8'(a));
            check("R4 drive unchanged", {16'h0, pin_drive}, {16'h0, exp_drive()});
            check("R4 level unchanged", {16'h0, pin_level}, {16'h0, exp_level()});
         end
      end
      read_all("R4 R6 map after writes");

      // R11: simultaneous read and write
      @(negedge clk);
      bus_addr = 8'h15; bus_wdata = 8'h5A; bus_we = 1'b1; bus_re = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_re = 1'b0;
      check("R11 read returns prior value", {24'h0, bus_rdata}, {24'h0, mdl['h15]});
      mdl['h15] = 8'h5A;
      rd(8'h15);
      check("R11 write still lands", {24'h0, bus_rdata}, 32'h5A);

      // R10: clock select codes against opposite source levels
      for (int k = 0; k < 6; k++) begin
         logic [7:0] code;
         code = (k == 0) ? 8'h00 : (k == 1) ? 8'h01 : 8'(k * 51);
         wr(8'h21, code);
         for (int lv = 0; lv < 2; lv++) begin
            host_clk = lv[0]; ext_clk = ~lv[0]; #1;
            check("R10 clock route", {31'h0, dev_clk},
                  {31'h0, (code == 8'h00) ? ext_clk : host_clk});
         end
         rd(8'h21);
         check("R6 clock select readback", {24'h0, bus_rdata}, {24'h0, code});
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule